// File: doc/BRIEF.md
# Dual-Issue Pairing Issue Logic

This block sits between an in-order instruction queue and two execution pipes of unequal capability. Each cycle it looks at the two oldest decoded instructions at the head of the queue. It decides whether they can leave together: the older one to the full primary pipe and the younger one to a restricted secondary pipe. It also decides whether only the older one leaves, in which case the secondary pipe stays idle. The queue learns how many entries to pop from a combinational consume count in the same cycle.

A younger instruction may go only to the secondary pipe. It pairs only when all of these hold: it is valid, its own pairing flag is set, its class code is in the accepted set for the secondary pipe, and it does not touch the register the older instruction writes. The chosen instructions appear as registered issue strobes and payloads one clock edge after the decision. One edge later, their tags come out as in-order retirement slots: the primary pipe's tag in slot 0 and the secondary pipe's tag in slot 1.

Top module: `pair_issue`

## Requirements
- R1: After reset, and until the first issue, `p_issue`, `s_issue` and both `ret_valid` bits are 0.
- R2: While `stall` is 1, `consume` is 0 in that cycle, and neither strobe is set after the next clock edge.
- R3: When `i0_valid` is 1 and `stall` is 0, slot 0 issues to the primary pipe. After the next clock edge, `p_issue` is 1 and `p_tag`, `p_cls`, `p_dst`, `p_srca` and `p_srcb` carry slot 0's fields.
- R4: When slot 0 issues and slot 1 may pair, slot 1 issues to the secondary pipe. After the next edge, `s_issue` is 1 and the `s_*` payload carries slot 1's fields.
- R5: Slot 1 does not pair when `i0_dst` is nonzero and equals `i1_srca`, `i1_srcb` or `i1_dst`. Register index 0 never creates a dependency.
- R6: Slot 1 pairs only if bit `i1_cls` of parameter `SEC_MASK` is 1. The default mask 8'b0001_0111 accepts class codes 0, 1, 2 and 4.
- R7: Slot 1 never pairs while `i1_sec_ok` is 0.
- R8: A valid slot 1 behind an invalid slot 0 is ignored: `consume` is 0 and nothing issues. A lone valid slot 0 issues alone, and the secondary pipe stays idle.
- R9: `consume` is always 0, 1 or 2. It equals the number of strobes set after the next clock edge.
- R10: One edge after an issue, `ret_valid[0]` is 1 with `ret_tag0` equal to the primary tag. `ret_valid[1]` is 1 with `ret_tag1` equal to the secondary tag only if the secondary pipe issued. `ret_valid[1]` is never 1 while `ret_valid[0]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Downstream hold; blocks all issue |
| i0_valid | input | 1 | Oldest queue entry present |
| i0_cls | input | 3 | Class code of oldest entry |
| i0_dst | input | 5 | Destination register of oldest entry |
| i0_srca | input | 5 | First source register of oldest entry |
| i0_srcb | input | 5 | Second source register of oldest entry |
| i0_tag | input | 6 | Retirement tag of oldest entry |
| i1_valid | input | 1 | Second-oldest entry present |
| i1_cls | input | 3 | Class code of second entry |
| i1_dst | input | 5 | Destination register of second entry |
| i1_srca | input | 5 | First source register of second entry |
| i1_srcb | input | 5 | Second source register of second entry |
| i1_sec_ok | input | 1 | Second entry may run on the secondary pipe |
| i1_tag | input | 6 | Retirement tag of second entry |
| consume | output | 2 | Entries popped from the queue this cycle |
| p_issue | output | 1 | Primary pipe issue strobe |
| p_cls | output | 3 | Primary payload class |
| p_dst | output | 5 | Primary payload destination |
| p_srca | output | 5 | Primary payload first source |
| p_srcb | output | 5 | Primary payload second source |
| p_tag | output | 6 | Primary payload tag |
| s_issue | output | 1 | Secondary pipe issue strobe |
| s_cls | output | 3 | Secondary payload class |
| s_dst | output | 5 | Secondary payload destination |
| s_srca | output | 5 | Secondary payload first source |
| s_srcb | output | 5 | Secondary payload second source |
| s_tag | output | 6 | Secondary payload tag |
| ret_valid | output | 2 | Retirement slot valids, bit 0 primary |
| ret_tag0 | output | 6 | Tag retiring first (primary) |
| ret_tag1 | output | 6 | Tag retiring second (secondary) |

## Verification
`consume` is combinational, so it is due in the same cycle as the queue entries that produce it. The bench reads it a moment after driving the inputs, before any edge. The issue strobes and payloads pass through one register and are read at the falling edge after the capturing rising edge. The bench sets the queue to idle right after that capturing edge, so no second issue can hide behind the first. The retirement slots pass through one further register and are read one cycle later again. At that point the expected strobes are all zero, because the queue was idle.

// File: rtl/pair_pkg.sv
package pair_pkg;

    localparam int REG_W     = 5;
    localparam int TAG_W     = 6;
    localparam int CLS_W     = 3;
    localparam int NUM_CLS   = 1 << CLS_W;
    localparam int NUM_LANES = 2;
    localparam int CNT_W     = $clog2(NUM_LANES + 1);

    typedef enum logic [CLS_W-1:0] {
        CLS_ALU    = 3'd0,
        CLS_SHIFT  = 3'd1,
        CLS_LOAD   = 3'd2,
        CLS_STORE  = 3'd3,
        CLS_BRANCH = 3'd4,
        CLS_FPU    = 3'd5,
        CLS_MUL    = 3'd6,
        CLS_SYS    = 3'd7
    } cls_e;

    typedef struct packed {
        logic             vld;
        cls_e             cls;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] srca;
        logic [REG_W-1:0] srcb;
        logic [TAG_W-1:0] tag;
    } lane_t;

    // Index 0 means "no register" and never links two instructions.
    function automatic logic reg_conflict(
        input logic [REG_W-1:0] older_dst,
        input logic [REG_W-1:0] y_dst,
        input logic [REG_W-1:0] y_srca,
        input logic [REG_W-1:0] y_srcb
    );
        logic named;
        named = (older_dst != '0);
        return named && ((y_srca == older_dst) ||
                         (y_srcb == older_dst) ||
                         (y_dst  == older_dst));
    endfunction

endpackage

// File: rtl/pair_dep_check.sv
module pair_dep_check
    import pair_pkg::*;
(
    input  logic [REG_W-1:0] older_dst,
    input  logic [REG_W-1:0] y_dst,
    input  logic [REG_W-1:0] y_srca,
    input  logic [REG_W-1:0] y_srcb,
    output logic             hazard
);

    always_comb begin
        hazard = reg_conflict(older_dst, y_dst, y_srca, y_srcb);
    end

endmodule

// File: rtl/pair_select.sv
module pair_select
    import pair_pkg::*;
#(
    parameter logic [NUM_CLS-1:0] SEC_MASK = 8'b0001_0111
)(
    input  logic             stall,
    input  logic             o_valid,
    input  logic             y_valid,
    input  cls_e             y_cls,
    input  logic             y_sec_ok,
    input  logic             hazard,
    output logic             go_pri,
    output logic             go_sec,
    output logic [CNT_W-1:0] consume
);

    logic class_fits;

    always_comb begin
        class_fits = SEC_MASK[y_cls];
        go_pri     = o_valid && !stall;
        go_sec     = go_pri && y_valid && y_sec_ok && class_fits && !hazard;
        consume    = CNT_W'(go_pri) + CNT_W'(go_sec);
    end

endmodule

// File: rtl/pair_lane_reg.sv
module pair_lane_reg
    import pair_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  lane_t d [NUM_LANES],
    output lane_t q [NUM_LANES]
);

    for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                q[ln] <= '0;
            end else if (d[ln].vld) begin
                q[ln] <= d[ln];
            end else begin
                q[ln] <= '0;
            end
        end
    end

endmodule

// File: rtl/pair_retire.sv
module pair_retire
    import pair_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LANES-1:0] vld_in,
    input  logic [TAG_W-1:0]     tag0_in,
    input  logic [TAG_W-1:0]     tag1_in,
    output logic [NUM_LANES-1:0] ret_valid,
    output logic [TAG_W-1:0]     ret_tag0,
    output logic [TAG_W-1:0]     ret_tag1
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ret_valid <= '0;
            ret_tag0  <= '0;
            ret_tag1  <= '0;
        end else begin
            // Slot order is program order: primary ahead of secondary.
            ret_valid[0] <= vld_in[0];
            ret_valid[1] <= vld_in[1] && vld_in[0];
            ret_tag0     <= vld_in[0] ? tag0_in : '0;
            ret_tag1     <= (vld_in[1] && vld_in[0]) ? tag1_in : '0;
        end
    end

endmodule

// File: rtl/pair_issue.sv
module pair_issue
    import pair_pkg::*;
#(
    parameter logic [NUM_CLS-1:0] SEC_MASK = 8'b0001_0111
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stall,
    input  logic                 i0_valid,
    input  logic [CLS_W-1:0]     i0_cls,
    input  logic [REG_W-1:0]     i0_dst,
    input  logic [REG_W-1:0]     i0_srca,
    input  logic [REG_W-1:0]     i0_srcb,
    input  logic [TAG_W-1:0]     i0_tag,
    input  logic                 i1_valid,
    input  logic [CLS_W-1:0]     i1_cls,
    input  logic [REG_W-1:0]     i1_dst,
    input  logic [REG_W-1:0]     i1_srca,
    input  logic [REG_W-1:0]     i1_srcb,
    input  logic                 i1_sec_ok,
    input  logic [TAG_W-1:0]     i1_tag,
    output logic [CNT_W-1:0]     consume,
    output logic                 p_issue,
    output logic [CLS_W-1:0]     p_cls,
    output logic [REG_W-1:0]     p_dst,
    output logic [REG_W-1:0]     p_srca,
    output logic [REG_W-1:0]     p_srcb,
    output logic [TAG_W-1:0]     p_tag,
    output logic                 s_issue,
    output logic [CLS_W-1:0]     s_cls,
    output logic [REG_W-1:0]     s_dst,
    output logic [REG_W-1:0]     s_srca,
    output logic [REG_W-1:0]     s_srcb,
    output logic [TAG_W-1:0]     s_tag,
    output logic [NUM_LANES-1:0] ret_valid,
    output logic [TAG_W-1:0]     ret_tag0,
    output logic [TAG_W-1:0]     ret_tag1
);

    logic  hazard;
    logic  go_pri;
    logic  go_sec;
    lane_t lane_d [NUM_LANES];
    lane_t lane_q [NUM_LANES];

    pair_dep_check u_dep (
        .older_dst (i0_dst),
        .y_dst     (i1_dst),
        .y_srca    (i1_srca),
        .y_srcb    (i1_srcb),
        .hazard    (hazard)
    );

    pair_select #(.SEC_MASK(SEC_MASK)) u_sel (
        .stall    (stall),
        .o_valid  (i0_valid),
        .y_valid  (i1_valid),
        .y_cls    (cls_e'(i1_cls)),
        .y_sec_ok (i1_sec_ok),
        .hazard   (hazard),
        .go_pri   (go_pri),
        .go_sec   (go_sec),
        .consume  (consume)
    );

    always_comb begin
        lane_d[0] = '{vld: go_pri, cls: cls_e'(i0_cls), dst: i0_dst,
                      srca: i0_srca, srcb: i0_srcb, tag: i0_tag};
        lane_d[1] = '{vld: go_sec, cls: cls_e'(i1_cls), dst: i1_dst,
                      srca: i1_srca, srcb: i1_srcb, tag: i1_tag};
    end

    pair_lane_reg u_lanes (
        .clk (clk),
        .rst (rst),
        .d   (lane_d),
        .q   (lane_q)
    );

    assign p_issue = lane_q[0].vld;
    assign p_cls   = lane_q[0].cls;
    assign p_dst   = lane_q[0].dst;
    assign p_srca  = lane_q[0].srca;
    assign p_srcb  = lane_q[0].srcb;
    assign p_tag   = lane_q[0].tag;
    assign s_issue = lane_q[1].vld;
    assign s_cls   = lane_q[1].cls;
    assign s_dst   = lane_q[1].dst;
    assign s_srca  = lane_q[1].srca;
    assign s_srcb  = lane_q[1].srcb;
    assign s_tag   = lane_q[1].tag;

    pair_retire u_ret (
        .clk       (clk),
        .rst       (rst),
        .vld_in    ({lane_q[1].vld, lane_q[0].vld}),
        .tag0_in   (lane_q[0].tag),
        .tag1_in   (lane_q[1].tag),
        .ret_valid (ret_valid),
        .ret_tag0  (ret_tag0),
        .ret_tag1  (ret_tag1)
    );

endmodule

// File: rtl/pair_issue_chk.sv
module pair_issue_chk
    import pair_pkg::*;
#(
    parameter logic [NUM_CLS-1:0] SEC_MASK = 8'b0001_0111
)(
    input logic                 clk,
    input logic                 rst,
    input logic                 stall,
    input logic [CNT_W-1:0]     consume,
    input logic                 p_issue,
    input logic [REG_W-1:0]     p_dst,
    input logic [TAG_W-1:0]     p_tag,
    input logic                 s_issue,
    input logic [CLS_W-1:0]     s_cls,
    input logic [REG_W-1:0]     s_dst,
    input logic [REG_W-1:0]     s_srca,
    input logic [REG_W-1:0]     s_srcb,
    input logic [TAG_W-1:0]     s_tag,
    input logic [NUM_LANES-1:0] ret_valid,
    input logic [TAG_W-1:0]     ret_tag0,
    input logic [TAG_W-1:0]     ret_tag1
);

    AST_CONSUME_RANGE: assert property (@(posedge clk) disable iff (rst)
        consume <= CNT_W'(2)); // R9
    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        stall |-> (consume == '0)); // R2
    AST_STALL_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
        stall |=> (!p_issue && !s_issue)); // R2
    AST_PAIR_COUNT: assert property (@(posedge clk) disable iff (rst)
        (consume == CNT_W'(2)) |=> (p_issue && s_issue)); // R9
    AST_SINGLE_COUNT: assert property (@(posedge clk) disable iff (rst)
        (consume == CNT_W'(1)) |=> (p_issue && !s_issue)); // R9
    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (consume == '0) |=> (!p_issue && !s_issue)); // R9
    AST_SEC_NEEDS_PRI: assert property (@(posedge clk) disable iff (rst)
        s_issue |-> p_issue); // R8
    AST_NO_DEP_PAIR: assert property (@(posedge clk) disable iff (rst)
        (s_issue && p_dst != '0) |->
        (s_srca != p_dst && s_srcb != p_dst && s_dst != p_dst)); // R5
    AST_SEC_CLASS: assert property (@(posedge clk) disable iff (rst)
        s_issue |-> SEC_MASK[s_cls]); // R6
    AST_RET_PRI: assert property (@(posedge clk) disable iff (rst)
        p_issue |=> (ret_valid[0] && ret_tag0 == $past(p_tag))); // R10
    AST_RET_SEC: assert property (@(posedge clk) disable iff (rst)
        s_issue |=> (ret_valid[1] && ret_tag1 == $past(s_tag))); // R10
    AST_RET_ORDER: assert property (@(posedge clk) disable iff (rst)
        ret_valid[1] |-> ret_valid[0]); // R10

endmodule

bind pair_issue pair_issue_chk #(.SEC_MASK(SEC_MASK)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .stall     (stall),
    .consume   (consume),
    .p_issue   (p_issue),
    .p_dst     (p_dst),
    .p_tag     (p_tag),
    .s_issue   (s_issue),
    .s_cls     (s_cls),
    .s_dst     (s_dst),
    .s_srca    (s_srca),
    .s_srcb    (s_srcb),
    .s_tag     (s_tag),
    .ret_valid (ret_valid),
    .ret_tag0  (ret_tag0),
    .ret_tag1  (ret_tag1)
);

// File: tb/tb_pair_issue.sv
module tb_pair_issue;

    localparam logic [7:0] MASK = 8'b0001_0111;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stall = 1'b0;
    logic       i0_valid = 1'b0;
    logic [2:0] i0_cls = '0;
    logic [4:0] i0_dst = '0, i0_srca = '0, i0_srcb = '0;
    logic [5:0] i0_tag = '0;
    logic       i1_valid = 1'b0;
    logic [2:0] i1_cls = '0;
    logic [4:0] i1_dst = '0, i1_srca = '0, i1_srcb = '0;
    logic       i1_sec_ok = 1'b0;
    logic [5:0] i1_tag = '0;
    logic [1:0] consume;
    logic       p_issue, s_issue;
    logic [2:0] p_cls, s_cls;
    logic [4:0] p_dst, p_srca, p_srcb, s_dst, s_srca, s_srcb;
    logic [5:0] p_tag, s_tag, ret_tag0, ret_tag1;
    logic [1:0] ret_valid;

    int checks = 0;
    int errors = 0;
    int seq = 0;

    always #5 clk = ~clk;

    pair_issue #(.SEC_MASK(MASK)) dut (
        .clk(clk), .rst(rst), .stall(stall),
        .i0_valid(i0_valid), .i0_cls(i0_cls), .i0_dst(i0_dst),
        .i0_srca(i0_srca), .i0_srcb(i0_srcb), .i0_tag(i0_tag),
        .i1_valid(i1_valid), .i1_cls(i1_cls), .i1_dst(i1_dst),
        .i1_srca(i1_srca), .i1_srcb(i1_srcb), .i1_sec_ok(i1_sec_ok),
        .i1_tag(i1_tag), .consume(consume),
        .p_issue(p_issue), .p_cls(p_cls), .p_dst(p_dst), .p_srca(p_srca),
        .p_srcb(p_srcb), .p_tag(p_tag),
        .s_issue(s_issue), .s_cls(s_cls), .s_dst(s_dst), .s_srca(s_srca),
        .s_srcb(s_srcb), .s_tag(s_tag),
        .ret_valid(ret_valid), .ret_tag0(ret_tag0), .ret_tag1(ret_tag1)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // kind: 0 independent, 1 src a hit, 2 src b hit, 3 dest hit, 4 older dest is 0
    task automatic run(input bit v0, input bit v1, input bit st,
                       input int cls, input bit sec, input int kind);
        bit ep, es, dep;
        logic [5:0] t0, t1;
        t0 = 6'(2 * seq);
        t1 = 6'(2 * seq + 1);
        seq++;
        @(negedge clk);
        stall = st;
        i0_valid = v0; i0_cls = 3'(7 - cls); i0_tag = t0;
        i0_dst = (kind == 4) ? 5'd0 : 5'd7; i0_srca = 5'd1; i0_srcb = 5'd2;
        i1_valid = v1; i1_cls = 3'(cls); i1_sec_ok = sec; i1_tag = t1;
        i1_srca = (kind == 1) ? 5'd7 : ((kind == 4) ? 5'd0 : 5'd9);
        i1_srcb = (kind == 2) ? 5'd7 : ((kind == 4) ? 5'd0 : 5'd10);
        i1_dst  = (kind == 3) ? 5'd7 : 5'd11;
        dep = (kind >= 1 && kind <= 3);
        ep = v0 && !st;
        es = ep && v1 && sec && MASK[cls] && !dep;
        #1;
        chk(st ? "R2 consume" : (!v0 ? "R8 consume" : "R9 consume"),
            int'(consume), int'(ep) + int'(es));
        @(posedge clk);
        #1;
        i0_valid = 1'b0; i1_valid = 1'b0; stall = 1'b0;
        @(negedge clk);
        chk("R3 p_issue", int'(p_issue), int'(ep));
        if (!v0 || st)
            chk("R8 s_issue", int'(s_issue), 0);
        else if (dep)
            chk("R5 s_issue", int'(s_issue), 0);
        else if (!sec)
            chk("R7 s_issue", int'(s_issue), 0);
        else
            chk("R6 s_issue", int'(s_issue), int'(es));
        if (ep) begin
            chk("R3 p_tag", int'(p_tag), int'(t0));
            chk("R3 p_dst", int'(p_dst), int'(i0_dst));
            chk("R3 p_cls", int'(p_cls), 7 - cls);
        end
        if (es) begin
            chk("R4 s_tag", int'(s_tag), int'(t1));
            chk("R4 s_srcb", int'(s_srcb), int'(i1_srcb));
            chk("R4 s_cls", int'(s_cls), cls);
        end
        @(negedge clk);
        chk("R10 ret_valid", int'(ret_valid), int'({es, ep}));
        if (ep) chk("R10 ret_tag0", int'(ret_tag0), int'(t0));
        if (es) chk("R10 ret_tag1", int'(ret_tag1), int'(t1));
        chk("R9 idle issue", int'(p_issue) + int'(s_issue), 0);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 p_issue", int'(p_issue), 0);
        chk("R1 s_issue", int'(s_issue), 0);
        chk("R1 ret_valid", int'(ret_valid), 0);
        chk("R1 consume", int'(consume), 0);

        for (int c = 0; c < 8; c++)
            for (int s = 0; s < 2; s++)
                for (int k = 0; k < 5; k++)
                    run(1'b1, 1'b1, 1'b0, c, s[0], k);

        for (int c = 0; c < 8; c++) begin
            run(1'b1, 1'b0, 1'b0, c, 1'b1, 0); // R8 lone older entry
            run(1'b0, 1'b1, 1'b0, c, 1'b1, 0); // R8 younger without older
            run(1'b1, 1'b1, 1'b1, c, 1'b1, 0); // R2 stall on a pairable pair
        end
        run(1'b0, 1'b0, 1'b1, 0, 1'b1, 0);     // R2 stall with empty queue

        finish_run();
    end

endmodule